// File: doc/BRIEF.md
# Load-Multiple-Word Sequencer

This block carries out a multi-register word load. On a start pulse it computes a base byte address, then fetches consecutive 32-bit words from memory. It places each word, zero-extended to the register width, into a run of general registers. The run begins at a chosen destination index and ends at the highest register, 31. Each word needs a one-cycle read request followed by a response from memory. After each word the address advances by four bytes and the register index by one.

The base address is the sign-extended 16-bit displacement added to the base register value. When the base register index is zero, zero is used in place of the register value. A single-cycle completion pulse follows the last register write, and the sequencer then accepts a new start. Memory latency is unbounded: the sequencer waits in place until a response arrives.

Top module: `lmw_seq`

## Requirements
- R1: The first read request carries the address (base index = 0 ? 0 : base value) + sign-extended displacement, computed modulo 2^64; the base value is ignored when the base index is 0.
- R2: Register writes go to indices RT, RT+1, … , 31 in that order, one write per word, for 32 − RT writes in total.
- R3: Each write carries the returned 32-bit word in bits [31:0] with bits [63:32] cleared.
- R4: Each read request after the first carries the previous request's address plus 4.
- R5: A start pulse that arrives while a sequence is running has no effect on that sequence's addresses, indices, data or length.
- R6: With RT = 31, exactly one word is requested and written, to register 31.
- R7: The done output is high for exactly one cycle: the cycle right after the write to register 31. In the following cycle no request, write or done is present, and a new start is accepted.
- R8: During and right after reset, the request, write and done outputs are low.
- R9: Each read request is high for one cycle. A response is accepted only while a word is outstanding, after any number of wait cycles. Every request produces exactly one write, and request, write and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (honoured only when idle) |
| rt_idx_i | input | 5 | First destination register index |
| ra_idx_i | input | 5 | Base register index; 0 selects a zero base |
| ra_val_i | input | 64 | Base register value |
| disp_i | input | 16 | Signed byte displacement |
| rd_req_o | output | 1 | One-cycle word read request |
| rd_addr_o | output | 64 | Byte address of the current word |
| rd_valid_i | input | 1 | Memory response valid |
| rd_data_i | input | 32 | Memory response word |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register index being written |
| wr_data_o | output | 64 | Zero-extended write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the following:
- a request lasts a single cycle;
- the request that follows a non-final write is four bytes above the one before;
- a write to register 31 is followed by done, and done lasts one cycle;
- the request, write and done events stay mutually exclusive;
- a start arriving mid-run leaves the address untouched.

Only the bench scenarios can show that the first address, the register indices, the write count and the zero-extended data are right. The bench sweeps every starting register from 0 to 31 with varied memory latency, base selection and displacement sign. It also includes a run whose address wraps past 2^64 and a run with a start pulse injected mid-sequence.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lmw_state_e;
endpackage

// File: rtl/lmw_addr_gen.sv
module lmw_addr_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              base_zero_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              step_i,
  output logic [XLEN-1:0]   addr_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_W / 8);

  // Start address: zero-or-register base plus sign-extended displacement.
  function automatic logic [XLEN-1:0] start_ea(input logic zero_base,
                                               input logic [XLEN-1:0] base,
                                               input logic [DISP_W-1:0] d);
    logic [XLEN-1:0] b;
    b = zero_base ? '0 : base;
    return b + {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  logic [XLEN-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= start_ea(base_zero_i, ra_val_i, disp_i);
    else if (step_i) addr_q <= addr_q + STEP;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/lmw_reg_counter.sv
module lmw_reg_counter #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] rt_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (load_i) idx_q <= rt_i;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/lmw_ctrl.sv
module lmw_ctrl
  import lmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rsp_valid_i,
  input  logic last_i,
  output logic load_o,
  output logic req_o,
  output logic wr_fire_o,
  output logic done_o,
  output logic busy_o
);
  lmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = last_i ? ST_DONE : ST_REQ;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign req_o     = (state_q == ST_REQ);
  assign wr_fire_o = (state_q == ST_WAIT) && rsp_valid_i;
  assign done_o    = (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);

  // R7: completion is a single-cycle pulse.
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !req_o);
endmodule

// File: rtl/lmw_seq.sv
module lmw_seq #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [XLEN-1:0]   ra_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              rd_req_o,
  output logic [XLEN-1:0]   rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX  = {IDX_W{1'b1}};
  localparam logic [XLEN-1:0]  ADDR_STEP = XLEN'(WORD_W / 8);

  function automatic logic [XLEN-1:0] zext_word(input logic [WORD_W-1:0] w);
    return {{(XLEN-WORD_W){1'b0}}, w};
  endfunction

  // Named internal events.
  logic load_evt;
  logic wr_evt;
  logic last_evt;
  logic busy;
  logic base_zero;

  assign base_zero = (ra_idx_i == '0);

  lmw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rsp_valid_i (rd_valid_i),
    .last_i      (last_evt),
    .load_o      (load_evt),
    .req_o       (rd_req_o),
    .wr_fire_o   (wr_evt),
    .done_o      (done_o),
    .busy_o      (busy)
  );

  lmw_addr_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .WORD_W(WORD_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_evt),
    .base_zero_i (base_zero),
    .ra_val_i    (ra_val_i),
    .disp_i      (disp_i),
    .step_i      (wr_evt),
    .addr_o      (rd_addr_o)
  );

  lmw_reg_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_evt),
    .rt_i   (rt_idx_i),
    .step_i (wr_evt),
    .idx_o  (wr_idx_o),
    .last_o (last_evt)
  );

  assign wr_en_o   = wr_evt;
  assign wr_data_o = zext_word(rd_data_i);

  // R9: a request lasts one cycle.
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);

  // R9: request, write and done never coincide.
  assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_o, wr_en_o, done_o}));

  // R4: after a non-final write the next request is one word further on.
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_idx_o != LAST_IDX) |=>
      (rd_req_o && rd_addr_o == $past(rd_addr_o) + ADDR_STEP));

  // R7: the write to the top register is followed by done.
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_idx_o == LAST_IDX) |=> done_o);

  // R5: a start while busy does not move the address.
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy && !wr_en_o) |=> $stable(rd_addr_o));
endmodule

// File: tb/tb_lmw_seq.sv
module tb_lmw_seq;
  localparam int XLEN = 64, WORD_W = 32, DISP_W = 16, IDX_W = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              start_i;
  logic [IDX_W-1:0]  rt_idx_i, ra_idx_i;
  logic [XLEN-1:0]   ra_val_i;
  logic [DISP_W-1:0] disp_i;
  logic              rd_req_o;
  logic [XLEN-1:0]   rd_addr_o;
  logic              rd_valid_i;
  logic [WORD_W-1:0] rd_data_i;
  logic              wr_en_o;
  logic [IDX_W-1:0]  wr_idx_o;
  logic [XLEN-1:0]   wr_data_o;
  logic              done_o;

  lmw_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rt_idx_i(rt_idx_i),
    .ra_idx_i(ra_idx_i), .ra_val_i(ra_val_i), .disp_i(disp_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .done_o(done_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int lat_g = 0;

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] ^ 32'h9E37_79B9;
  endfunction

  function automatic logic [63:0] sext16(input logic [15:0] d);
    logic [63:0] r;
    r = {48'd0, d};
    if (d[15]) r = r - 64'h1_0000;
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Memory responder: answers each request after 1 + lat_g cycles.
  initial begin
    logic [63:0] a;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk);
      while (rd_req_o === 1'b1) begin
        a = rd_addr_o;
        @(negedge clk);
        repeat (lat_g) @(negedge clk);
        rd_valid_i = 1'b1;
        rd_data_i  = mem_word(a);
        @(negedge clk);
        rd_valid_i = 1'b0;
      end
    end
  end

  task automatic run_lmw(input int rt, input int raidx, input logic [63:0] raval,
                         input logic [15:0] disp, input bit inject);
    logic [63:0] base, exp_a;
    int nreq = 0, nwr = 0, last_wr = -1, done_at = -1, cyc = 0;
    bit prev_req = 0;
    base = ((raidx == 0) ? 64'd0 : raval) + sext16(disp);
    @(negedge clk);
    start_i = 1'b1; rt_idx_i = 5'(rt); ra_idx_i = 5'(raidx);
    ra_val_i = raval; disp_i = disp;
    while (done_at < 0 && cyc < 600) begin
      @(negedge clk);
      cyc++;
      start_i = inject && (cyc == 3);
      if (inject) begin
        rt_idx_i = 5'd0; ra_idx_i = 5'd4; ra_val_i = 64'h5555; disp_i = 16'h7000;
      end
      #1;
      if (rd_req_o) begin
        exp_a = base + 64'(4 * nreq);
        check(rd_addr_o == exp_a, (nreq == 0) ? "R1 start address" : "R4 address step",
              rd_addr_o, exp_a);
        check(!prev_req, "R9 single-cycle request", 64'(prev_req), 64'd0);
        nreq++;
      end
      prev_req = rd_req_o;
      if (wr_en_o) begin
        check(wr_idx_o == 5'(rt + nwr), "R2 register index", 64'(wr_idx_o), 64'(rt + nwr));
        exp_a = {32'd0, mem_word(base + 64'(4 * nwr))};
        check(wr_data_o == exp_a, "R3 zero-extended data", wr_data_o, exp_a);
        nwr++;
        last_wr = cyc;
      end
      if (done_o) done_at = cyc;
    end
    check(nwr == 32 - rt, (rt == 31) ? "R6 single word" : "R2 word count",
          64'(nwr), 64'(32 - rt));
    if (inject) check(nwr == 32 - rt, "R5 mid-run start ignored", 64'(nwr), 64'(32 - rt));
    check(nreq == nwr, "R9 one write per request", 64'(nwr), 64'(nreq));
    check(done_at == last_wr + 1, "R7 done after last write", 64'(done_at), 64'(last_wr + 1));
    @(negedge clk);
    #1;
    check(!done_o && !rd_req_o && !wr_en_o, "R7 back to idle",
          {61'd0, done_o, rd_req_o, wr_en_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_sim();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rt_idx_i = '0; ra_idx_i = '0;
    ra_val_i = '0; disp_i = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!rd_req_o && !wr_en_o && !done_o, "R8 reset outputs",
          {61'd0, rd_req_o, wr_en_o, done_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!rd_req_o && !wr_en_o && !done_o, "R8 after reset",
          {61'd0, rd_req_o, wr_en_o, done_o}, 64'd0);

    // Sweep every starting register.
    for (int rt = 0; rt < 32; rt++) begin
      int raidx;
      logic [63:0] rv;
      logic [15:0] d;
      lat_g = rt % 4;
      raidx = (rt % 3 == 0) ? 0 : (rt % 7) + 1;
      rv    = (rt % 3 == 0) ? 64'hDEAD_BEEF_0BAD_F00D
                            : 64'h0000_1234_5678_0000 + 64'(rt) * 64'h1_0010;
      d     = (rt % 2 == 1) ? 16'(16'hFFF0 - 16'(rt * 16)) : 16'(16'h0100 + 16'(rt * 8));
      run_lmw(rt, raidx, rv, d, 1'b0);
    end

    // Address wraps past the top of the space.
    lat_g = 1;
    run_lmw(28, 9, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0000, 1'b0);
    // R6: top register only, slow memory.
    lat_g = 3;
    run_lmw(31, 2, 64'h0000_0000_8000_0000, 16'h8000, 1'b0);
    // R5: start pulse in the middle of a run.
    lat_g = 2;
    run_lmw(20, 3, 64'h0000_0000_0001_0000, 16'h0040, 1'b1);

    finish_sim();
  end
endmodule